// File: doc/BRIEF.md
# Privileged Return and Trap-Check Unit

This block handles the four privileged control operations of a small in-order core: return from supervisor trap, return from machine trap, wait-for-interrupt, and the address-translation fence. The decode stage presents one operation per cycle on a one-hot request bus. It also supplies the hart's current privilege level, the status word, the two saved exception PCs, a flag that enables compressed instructions and a flag that selects the newer or older privileged-spec behaviour.

In the cycle of the request, the unit decides combinationally whether the operation is illegal or misaligned, and reports a trap flag with a cause code. If the operation is accepted, the result registers load on the next clock edge. For a return, these are the rebuilt status word, the new privilege level and the return PC, together with a one-cycle redirect pulse. For WFI, the unit issues a one-cycle halt pulse. For the fence, it issues a one-cycle TLB-flush pulse. The surrounding core writes the registered status and privilege back into its own state.

Top module: `xret_trap_unit`

## Requirements
- R1: An SRET issued at user privilege, or an MRET issued below machine privilege, raises exception cause 2 (illegal instruction). On the following edge there is no redirect, halt or flush pulse, and the registered status and privilege keep their values. Privilege encoding: user 0, supervisor 1, machine 3.
- R2: When compressed instructions are disabled and the saved PC that would be returned to has bit 1 or bit 0 set, SRET or MRET raises cause 0 (misaligned instruction address). When compressed instructions are enabled, the same PC is returned.
- R3: For SRET, the privilege check comes before the misalignment check, and the misalignment check comes before the TSR check.
- R4: When the newer-version flag is 1, SRET raises cause 2 whenever status bit 22 (TSR) is set. When the flag is 0, that bit has no effect.
- R5: An accepted SRET under the newer version does the following on the next edge. It copies status bit 5 (SPIE) into bit 1 (SIE), clears bit 5 and bit 8 (SPP), and keeps all other bits. It sets the privilege to the old bit 8, loads the return PC with the saved supervisor PC, and pulses the redirect output for one cycle.
- R6: An accepted MRET under the newer version does the following. It copies bit 7 (MPIE) into bit 3 (MIE), clears bit 7 and bits 12:11 (MPP), and sets the privilege to the old bits 12:11. It loads the return PC with the saved machine PC and pulses the redirect output.
- R7: When the newer-version flag is 0, the previous-enable bit is written into status bit N, where N is the previous privilege value (bit 0 for user), instead of into bit 1 or bit 3. The fixed SIE or MIE bit is then left unchanged.
- R8: WFI raises cause 2 when all three of these hold: privilege is supervisor, status bit 21 (TW) is set, and the newer-version flag is 1. Otherwise WFI produces a one-cycle halt pulse on the next edge.
- R9: The translation fence raises cause 2 at user privilege. It also raises cause 2 at supervisor privilege when status bit 20 (TVM) is set and the newer-version flag is 1. Otherwise it produces a one-cycle TLB-flush pulse on the next edge.
- R10: The request bits are SRET 0, MRET 1, WFI 2 and fence 3. A request with no bit set, or with more than one bit set, raises no exception, produces no pulse and changes no registered state.
- R11: After reset the registered status is 0, the privilege is machine (3), and the redirect, halt and flush outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | One-hot operation request: bit0 SRET, bit1 MRET, bit2 WFI, bit3 fence |
| priv_i | input | 2 | Current privilege level |
| status_i | input | XLEN | Current status word |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| mepc_i | input | XLEN | Saved machine exception PC |
| c_en_i | input | 1 | Compressed instructions enabled |
| new_ver_i | input | 1 | 1 selects newer-spec trap and restore rules |
| exc_valid_o | output | 1 | Operation traps (combinational) |
| exc_cause_o | output | 4 | Cause code: 0 misaligned, 2 illegal |
| redirect_o | output | 1 | One-cycle pulse after an accepted return |
| ret_pc_o | output | XLEN | Return PC, loaded with the redirect |
| status_o | output | XLEN | Registered status after the last return |
| priv_o | output | 2 | Registered privilege after the last return |
| halt_o | output | 1 | One-cycle halt pulse after an accepted WFI |
| tlb_flush_o | output | 1 | One-cycle flush pulse after an accepted fence |

## Verification
Returns are issued with status words in which the previous-enable bit and the previous-privilege field differ from the current enable bits, so a swapped source or destination bit changes the result. Each gating bit (TSR, TW, TVM) is tried with the version flag at both settings and at more than one privilege. This separates a missing version qualifier from a missing privilege qualifier. The misalignment case is run with compressed instructions off and on. Combinations in which two trap conditions are true at once show the check order. Empty and double requests are shown to change nothing.

// File: rtl/xret_pkg.sv
package xret_pkg;

    localparam int unsigned REQ_W     = 4;
    localparam int unsigned REQ_SRET  = 0;
    localparam int unsigned REQ_MRET  = 1;
    localparam int unsigned REQ_WFI   = 2;
    localparam int unsigned REQ_FENCE = 3;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    // status word bit positions
    localparam int unsigned ST_SIE    = 1;
    localparam int unsigned ST_MIE    = 3;
    localparam int unsigned ST_SPIE   = 5;
    localparam int unsigned ST_MPIE   = 7;
    localparam int unsigned ST_SPP    = 8;
    localparam int unsigned ST_MPP_LO = 11;
    localparam int unsigned ST_TVM    = 20;
    localparam int unsigned ST_TW     = 21;
    localparam int unsigned ST_TSR    = 22;

    localparam int unsigned CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;

endpackage

// File: rtl/xret_trap_check.sv
module xret_trap_check
    import xret_pkg::*;
(
    input  logic [REQ_W-1:0]   req,
    input  logic [1:0]         priv,
    input  logic               tsr,
    input  logic               tw,
    input  logic               tvm,
    input  logic [1:0]         sepc_lo,
    input  logic [1:0]         mepc_lo,
    input  logic               c_en,
    input  logic               new_ver,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic               do_sret,
    output logic               do_mret,
    output logic               do_wfi,
    output logic               do_fence
);

    logic single;

    always_comb begin
        single    = (req != '0) && ((req & (req - 1'b1)) == '0);
        exc_valid = 1'b0;
        exc_cause = CAUSE_ILLEGAL;
        do_sret   = 1'b0;
        do_mret   = 1'b0;
        do_wfi    = 1'b0;
        do_fence  = 1'b0;
        if (single) begin
            if (req[REQ_SRET]) begin
                if (priv < PRIV_S) begin
                    exc_valid = 1'b1;
                end else if (!c_en && (sepc_lo != 2'b00)) begin
                    exc_valid = 1'b1;
                    exc_cause = CAUSE_MISALIGN;
                end else if (new_ver && tsr) begin
                    exc_valid = 1'b1;
                end else begin
                    do_sret = 1'b1;
                end
            end else if (req[REQ_MRET]) begin
                if (priv != PRIV_M) begin
                    exc_valid = 1'b1;
                end else if (!c_en && (mepc_lo != 2'b00)) begin
                    exc_valid = 1'b1;
                    exc_cause = CAUSE_MISALIGN;
                end else begin
                    do_mret = 1'b1;
                end
            end else if (req[REQ_WFI]) begin
                if ((priv == PRIV_S) && new_ver && tw) begin
                    exc_valid = 1'b1;
                end else begin
                    do_wfi = 1'b1;
                end
            end else begin
                if ((priv < PRIV_S) || ((priv == PRIV_S) && new_ver && tvm)) begin
                    exc_valid = 1'b1;
                end else begin
                    do_fence = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xret_status_calc.sv
module xret_status_calc
    import xret_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            is_mret,
    input  logic            new_ver,
    input  logic [XLEN-1:0] status,
    output logic [XLEN-1:0] status_n,
    output logic [1:0]      priv_n
);

    logic [1:0] prev;
    logic       pie;

    always_comb begin
        prev     = is_mret ? status[ST_MPP_LO +: 2] : {1'b0, status[ST_SPP]};
        pie      = is_mret ? status[ST_MPIE] : status[ST_SPIE];
        status_n = status;
        if (new_ver) begin
            if (is_mret) status_n[ST_MIE] = pie;
            else         status_n[ST_SIE] = pie;
        end else begin
            status_n[prev] = pie;
        end
        if (is_mret) begin
            status_n[ST_MPIE]        = 1'b0;
            status_n[ST_MPP_LO +: 2] = PRIV_U;
        end else begin
            status_n[ST_SPIE] = 1'b0;
            status_n[ST_SPP]  = 1'b0;
        end
        priv_n = prev;
    end

endmodule

// File: rtl/xret_trap_unit.sv
module xret_trap_unit
    import xret_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         req_i,
    input  logic [1:0]         priv_i,
    input  logic [XLEN-1:0]    status_i,
    input  logic [XLEN-1:0]    sepc_i,
    input  logic [XLEN-1:0]    mepc_i,
    input  logic               c_en_i,
    input  logic               new_ver_i,
    output logic               exc_valid_o,
    output logic [3:0]         exc_cause_o,
    output logic               redirect_o,
    output logic [XLEN-1:0]    ret_pc_o,
    output logic [XLEN-1:0]    status_o,
    output logic [1:0]         priv_o,
    output logic               halt_o,
    output logic               tlb_flush_o
);

    typedef struct packed {
        logic            redirect;
        logic            halt;
        logic            flush;
        logic [XLEN-1:0] ret_pc;
        logic [XLEN-1:0] status;
        logic [1:0]      priv;
    } state_t;

    state_t st_d, st_q;

    logic            do_sret, do_mret, do_wfi, do_fence;
    logic [XLEN-1:0] calc_status;
    logic [1:0]      calc_priv;

    xret_trap_check u_check (
        .req       (req_i),
        .priv      (priv_i),
        .tsr       (status_i[ST_TSR]),
        .tw        (status_i[ST_TW]),
        .tvm       (status_i[ST_TVM]),
        .sepc_lo   (sepc_i[1:0]),
        .mepc_lo   (mepc_i[1:0]),
        .c_en      (c_en_i),
        .new_ver   (new_ver_i),
        .exc_valid (exc_valid_o),
        .exc_cause (exc_cause_o),
        .do_sret   (do_sret),
        .do_mret   (do_mret),
        .do_wfi    (do_wfi),
        .do_fence  (do_fence)
    );

    xret_status_calc #(.XLEN(XLEN)) u_calc (
        .is_mret  (do_mret),
        .new_ver  (new_ver_i),
        .status   (status_i),
        .status_n (calc_status),
        .priv_n   (calc_priv)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redirect = do_sret | do_mret;
        st_d.halt     = do_wfi;
        st_d.flush    = do_fence;
        if (do_sret || do_mret) begin
            st_d.ret_pc = do_mret ? mepc_i : sepc_i;
            st_d.status = calc_status;
            st_d.priv   = calc_priv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.redirect <= 1'b0;
            st_q.halt     <= 1'b0;
            st_q.flush    <= 1'b0;
            st_q.ret_pc   <= '0;
            st_q.status   <= '0;
            st_q.priv     <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o  = st_q.redirect;
    assign halt_o      = st_q.halt;
    assign tlb_flush_o = st_q.flush;
    assign ret_pc_o    = st_q.ret_pc;
    assign status_o    = st_q.status;
    assign priv_o      = st_q.priv;

endmodule

// File: rtl/xret_trap_unit_chk.sv
module xret_trap_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      req_i,
    input logic [1:0]      priv_i,
    input logic            tsr_i,
    input logic [XLEN-1:0] sepc_i,
    input logic [XLEN-1:0] mepc_i,
    input logic            c_en_i,
    input logic            new_ver_i,
    input logic            exc_valid_o,
    input logic [3:0]      exc_cause_o,
    input logic            redirect_o,
    input logic [XLEN-1:0] ret_pc_o,
    input logic [XLEN-1:0] status_o,
    input logic [1:0]      priv_o,
    input logic            halt_o,
    input logic            tlb_flush_o
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_TRAP_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |=> (!redirect_o && !halt_o && !tlb_flush_o && $stable(status_o) && $stable(priv_o))); // R1

    AST_MISALIGN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 4'b0010 && priv_i == 2'd3 && !c_en_i && mepc_i[1:0] != 2'b00)
        |-> (exc_valid_o && exc_cause_o == 4'd0)); // R2

    AST_TSR_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 4'b0001 && priv_i != 2'd0 && (c_en_i || sepc_i[1:0] == 2'b00) && new_ver_i && tsr_i)
        |-> (exc_valid_o && exc_cause_o == 4'd2)); // R4

    AST_SRET_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && redirect_o && $past(req_i) == 4'b0001)
        |-> (!status_o[5] && !status_o[8] && ret_pc_o == $past(sepc_i))); // R5

    AST_MRET_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && redirect_o && $past(req_i) == 4'b0010)
        |-> (!status_o[7] && status_o[12:11] == 2'b00 && ret_pc_o == $past(mepc_i))); // R6

    AST_WFI_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 4'b0100 && !exc_valid_o) |=> halt_o); // R8

    AST_USER_FENCE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 4'b1000 && priv_i == 2'd0) |-> (exc_valid_o && exc_cause_o == 4'd2)); // R9

    AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 4'b0000) |-> !exc_valid_o); // R10

    AST_SINGLE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({redirect_o, halt_o, tlb_flush_o})); // R10

endmodule

bind xret_trap_unit xret_trap_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .priv_i      (priv_i),
    .tsr_i       (status_i[22]),
    .sepc_i      (sepc_i),
    .mepc_i      (mepc_i),
    .c_en_i      (c_en_i),
    .new_ver_i   (new_ver_i),
    .exc_valid_o (exc_valid_o),
    .exc_cause_o (exc_cause_o),
    .redirect_o  (redirect_o),
    .ret_pc_o    (ret_pc_o),
    .status_o    (status_o),
    .priv_o      (priv_o),
    .halt_o      (halt_o),
    .tlb_flush_o (tlb_flush_o)
);

// File: tb/tb_xret_trap_unit.sv
`timescale 1ns/1ps
module tb_xret_trap_unit;

    localparam int XLEN = 32;
    localparam logic [3:0] Q_SRET = 4'b0001, Q_MRET = 4'b0010,
                           Q_WFI  = 4'b0100, Q_FENCE = 4'b1000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      req_i = '0;
    logic [1:0]      priv_i = '0;
    logic [XLEN-1:0] status_i = '0, sepc_i = '0, mepc_i = '0;
    logic            c_en_i = 1'b0, new_ver_i = 1'b1;
    logic            exc_valid_o, redirect_o, halt_o, tlb_flush_o;
    logic [3:0]      exc_cause_o;
    logic [XLEN-1:0] ret_pc_o, status_o;
    logic [1:0]      priv_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    xret_trap_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .priv_i(priv_i),
        .status_i(status_i), .sepc_i(sepc_i), .mepc_i(mepc_i),
        .c_en_i(c_en_i), .new_ver_i(new_ver_i),
        .exc_valid_o(exc_valid_o), .exc_cause_o(exc_cause_o),
        .redirect_o(redirect_o), .ret_pc_o(ret_pc_o), .status_o(status_o),
        .priv_o(priv_o), .halt_o(halt_o), .tlb_flush_o(tlb_flush_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // apply a request at the falling edge, settle combinational outputs
    task automatic issue(input logic [3:0] r, input logic [1:0] p, input logic [31:0] st,
                         input logic [31:0] sp, input logic [31:0] mp,
                         input logic ce, input logic nv);
        @(negedge clk);
        req_i = r; priv_i = p; status_i = st; sepc_i = sp; mepc_i = mp;
        c_en_i = ce; new_ver_i = nv;
        #1;
    endtask

    // cross one rising edge, drop the request
    task automatic step();
        @(negedge clk);
        req_i = '0;
        #1;
    endtask

    task automatic t_reset();
        chk("R11 status", status_o, 32'h0);
        chk("R11 priv", {30'd0, priv_o}, 32'd3);
        chk("R11 pulses", {29'd0, redirect_o, halt_o, tlb_flush_o}, 32'd0);
    endtask

    task automatic t_priv_gate();
        logic [31:0] s0;
        logic [1:0]  p0;
        s0 = status_o; p0 = priv_o;
        issue(Q_SRET, 2'd0, 32'h120, 32'h100, 32'h0, 1'b1, 1'b1);
        chk("R1 sret user exc", {31'd0, exc_valid_o}, 32'd1);
        chk("R1 sret user cause", {28'd0, exc_cause_o}, 32'd2);
        step();
        chk("R1 no redirect", {31'd0, redirect_o}, 32'd0);
        chk("R1 status kept", status_o, s0);
        chk("R1 priv kept", {30'd0, priv_o}, {30'd0, p0});
        issue(Q_MRET, 2'd1, 32'h880, 32'h0, 32'h200, 1'b1, 1'b1);
        chk("R1 mret super cause", {27'd0, exc_valid_o, exc_cause_o}, 32'h12);
        step();
        chk("R1 mret no redirect", {31'd0, redirect_o}, 32'd0);
        chk("R1 mret status kept", status_o, s0);
    endtask

    task automatic t_misalign();
        issue(Q_MRET, 2'd3, 32'h0, 32'h0, 32'h102, 1'b0, 1'b1);
        chk("R2 mret misaligned", {27'd0, exc_valid_o, exc_cause_o}, 32'h10);
        step();
        chk("R2 no redirect", {31'd0, redirect_o}, 32'd0);
        issue(Q_MRET, 2'd3, 32'h0, 32'h0, 32'h102, 1'b1, 1'b1);
        chk("R2 compressed ok", {31'd0, exc_valid_o}, 32'd0);
        step();
        chk("R2 redirect", {31'd0, redirect_o}, 32'd1);
        chk("R2 ret pc", ret_pc_o, 32'h102);
        issue(Q_SRET, 2'd1, 32'h0, 32'h201, 32'h0, 1'b0, 1'b1);
        chk("R2 sret misaligned", {27'd0, exc_valid_o, exc_cause_o}, 32'h10);
        step();
    endtask

    task automatic t_precedence();
        issue(Q_SRET, 2'd0, 32'h400000, 32'h3, 32'h0, 1'b0, 1'b1);
        chk("R3 priv beats misalign", {27'd0, exc_valid_o, exc_cause_o}, 32'h12);
        step();
        issue(Q_SRET, 2'd1, 32'h400000, 32'h2, 32'h0, 1'b0, 1'b1);
        chk("R3 misalign beats tsr", {27'd0, exc_valid_o, exc_cause_o}, 32'h10);
        step();
    endtask

    task automatic t_tsr();
        issue(Q_SRET, 2'd1, 32'h400020, 32'h40, 32'h0, 1'b0, 1'b1);
        chk("R4 tsr traps", {27'd0, exc_valid_o, exc_cause_o}, 32'h12);
        step();
        issue(Q_SRET, 2'd1, 32'h400020, 32'h40, 32'h0, 1'b0, 1'b0);
        chk("R4 tsr ignored old", {31'd0, exc_valid_o}, 32'd0);
        step();
        chk("R4 redirect", {31'd0, redirect_o}, 32'd1);
        chk("R7 old sret into bit0", status_o, 32'h400001);
        chk("R7 old sret priv", {30'd0, priv_o}, 32'd0);
    endtask

    task automatic t_sret_new();
        issue(Q_SRET, 2'd3, 32'h128, 32'h8000_0040, 32'h0, 1'b0, 1'b1);
        chk("R5 no exc", {31'd0, exc_valid_o}, 32'd0);
        step();
        chk("R5 redirect", {31'd0, redirect_o}, 32'd1);
        chk("R5 status", status_o, 32'h00A);
        chk("R5 priv", {30'd0, priv_o}, 32'd1);
        chk("R5 ret pc", ret_pc_o, 32'h8000_0040);
        @(negedge clk); #1;
        chk("R5 pulse one cycle", {31'd0, redirect_o}, 32'd0);
    endtask

    task automatic t_mret_new();
        issue(Q_MRET, 2'd3, 32'h200880, 32'h0, 32'h8000_1000, 1'b0, 1'b1);
        chk("R6 no exc", {31'd0, exc_valid_o}, 32'd0);
        step();
        chk("R6 redirect", {31'd0, redirect_o}, 32'd1);
        chk("R6 status", status_o, 32'h200008);
        chk("R6 priv", {30'd0, priv_o}, 32'd1);
        chk("R6 ret pc", ret_pc_o, 32'h8000_1000);
    endtask

    task automatic t_old_ver();
        issue(Q_MRET, 2'd3, 32'h1880, 32'h0, 32'h400, 1'b0, 1'b0);
        step();
        chk("R7 mret mpp3 status", status_o, 32'h8);
        chk("R7 mret mpp3 priv", {30'd0, priv_o}, 32'd3);
        issue(Q_MRET, 2'd3, 32'h80A, 32'h0, 32'h400, 1'b0, 1'b0);
        step();
        chk("R7 mret mpp1 status", status_o, 32'h8);
        chk("R7 mret mpp1 priv", {30'd0, priv_o}, 32'd1);
        issue(Q_SRET, 2'd1, 32'h120, 32'h80, 32'h0, 1'b0, 1'b0);
        step();
        chk("R7 sret spp1 status", status_o, 32'h2);
        chk("R7 sret spp1 priv", {30'd0, priv_o}, 32'd1);
    endtask

    task automatic t_wfi();
        issue(Q_WFI, 2'd1, 32'h200000, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R8 tw traps", {27'd0, exc_valid_o, exc_cause_o}, 32'h12);
        step();
        chk("R8 no halt", {31'd0, halt_o}, 32'd0);
        issue(Q_WFI, 2'd0, 32'h200000, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R8 user no trap", {31'd0, exc_valid_o}, 32'd0);
        step();
        chk("R8 halt", {31'd0, halt_o}, 32'd1);
        @(negedge clk); #1;
        chk("R8 halt one cycle", {31'd0, halt_o}, 32'd0);
        issue(Q_WFI, 2'd1, 32'h200000, 32'h0, 32'h0, 1'b0, 1'b0);
        chk("R8 old no trap", {31'd0, exc_valid_o}, 32'd0);
        step();
        chk("R8 old halt", {31'd0, halt_o}, 32'd1);
    endtask

    task automatic t_fence();
        issue(Q_FENCE, 2'd0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R9 user traps", {27'd0, exc_valid_o, exc_cause_o}, 32'h12);
        step();
        chk("R9 no flush", {31'd0, tlb_flush_o}, 32'd0);
        issue(Q_FENCE, 2'd1, 32'h100000, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R9 tvm traps", {27'd0, exc_valid_o, exc_cause_o}, 32'h12);
        step();
        issue(Q_FENCE, 2'd1, 32'h100000, 32'h0, 32'h0, 1'b0, 1'b0);
        chk("R9 old no trap", {31'd0, exc_valid_o}, 32'd0);
        step();
        chk("R9 flush", {31'd0, tlb_flush_o}, 32'd1);
        issue(Q_FENCE, 2'd3, 32'h100000, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R9 machine no trap", {31'd0, exc_valid_o}, 32'd0);
        step();
        chk("R9 machine flush", {31'd0, tlb_flush_o}, 32'd1);
        @(negedge clk); #1;
        chk("R9 flush one cycle", {31'd0, tlb_flush_o}, 32'd0);
    endtask

    task automatic t_idle();
        logic [31:0] s0;
        logic [1:0]  p0;
        s0 = status_o; p0 = priv_o;
        issue(4'b0000, 2'd0, 32'h1880, 32'h3, 32'h3, 1'b0, 1'b1);
        chk("R10 empty no exc", {31'd0, exc_valid_o}, 32'd0);
        step();
        chk("R10 empty no pulse", {29'd0, redirect_o, halt_o, tlb_flush_o}, 32'd0);
        issue(4'b0011, 2'd3, 32'h1880, 32'h40, 32'h80, 1'b1, 1'b1);
        chk("R10 double no exc", {31'd0, exc_valid_o}, 32'd0);
        step();
        chk("R10 double no pulse", {29'd0, redirect_o, halt_o, tlb_flush_o}, 32'd0);
        chk("R10 status kept", status_o, s0);
        chk("R10 priv kept", {30'd0, priv_o}, {30'd0, p0});
    endtask

    initial begin
        #(20.0 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_priv_gate();
        t_misalign();
        t_precedence();
        t_tsr();
        t_sret_new();
        t_mret_new();
        t_old_ver();
        t_wfi();
        t_fence();
        t_idle();
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule